// File: doc/BRIEF.md
# Match-Capture Timer Counter

This block is a general-purpose timer with a prescaler, a main count register, four compare channels and four capture channels. The count source is either every system clock cycle or a chosen edge of one of the capture pins, taken after a two-flop synchroniser. A prescale counter divides the source, and the main count advances each time the prescale counter reaches its limit.

Each compare channel fires once per count advance that leaves its compare value. When it fires, the channel can set a sticky interrupt flag, return the count to zero, stop the counter, and drive its pin low, high, toggled or unchanged. Each capture channel copies the count into its own register on a rising, falling or either edge of its pin, and can set a sticky interrupt flag. The interrupt output is the OR of all flags.

A control state machine has three states. IDLE holds the count. RUN counts. HOLD keeps the count and the prescale counter at zero. A control write moves the machine between the states: hold=1 goes to HOLD, otherwise en=1 goes to RUN and en=0 goes to IDLE. A compare channel with stop enabled moves the machine from RUN to IDLE when it fires. A control write in the same cycle takes priority over the stop.

Software reaches the block through a synchronous register port. Writes take effect at the clock edge. Read data appears one cycle after the address. Register addresses:
- 0 control: bit0 en (reads 1 in RUN), bit1 hold (reads 1 in HOLD), bits[3:2] source mode, bits[5:4] source pin.
- 1 flags.
- 2 count.
- 3 prescale limit.
- 4 prescale counter.
- 5 compare actions.
- 6 capture setup.
- 7 pin control.
- 8 to 11 compare values of channels 0 to 3.
- 12 to 15 capture registers of channels 0 to 3, read-only.

Top module: `mc_timer`

## Requirements
- R1: After reset the state is IDLE, and the count, the prescale counter, all flags, every match pin and `irq` are zero.
- R2: With source mode 00 (every clock) in RUN, the prescale counter steps each cycle and wraps to 0 after reaching the prescale limit P. The count advances once per P+1 cycles.
- R3: A channel whose interrupt bit is set (address 5, bit 3i) sets match flag i (address 1, bit i) when it fires. The flags are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. `irq` is high exactly when some flag is set. The interrupt choice does not affect the channel's other actions.
- R4: A channel with reset enabled (address 5, bit 3i+1) returns the count to 0 on the advance where the count equals its compare value V. The counter then cycles with period V+1 advances.
- R5: A channel with stop enabled (address 5, bit 3i+2) moves RUN to IDLE when it fires, and the count stays at V.
- R6: When one event both resets and stops, the count becomes 0 and the state becomes IDLE on the same edge.
- R7: Pin i takes action code 00 none, 01 low, 10 high or 11 toggle from address 7, bits[4+2i+1:4+2i], when channel i fires. Bits[3:0] of address 7 read the pin levels, and a write to them sets the levels directly. A firing channel overrides a level written in the same cycle.
- R8: Capture channel i has setup bits at address 6: bit 3i rising, bit 3i+1 falling, bit 3i+2 interrupt. An enabled edge on `cap_in[i]` copies the count into capture register i, and the interrupt bit then sets flag 4+i. An edge that is not enabled changes neither the register nor the flag.
- R9: Source modes 01, 10 and 11 count rising, falling or both edges of the pin selected by control bits[5:4] instead of clock cycles, still divided by the prescaler.
- R10: A channel fires only on an advance. A prescaled count resting on V for several cycles causes one action. A counter that is not running, sitting on V, causes none.
- R11: In HOLD the count and prescale counter stay at 0 and writes to them are ignored. Leaving HOLD with en=1 starts counting from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Read data, one cycle after the address |
| cap_in | input | NCH | Capture and count-source pins |
| mat_out | output | NCH | Match output pins |
| irq | output | 1 | OR of all sticky flags |

## Verification
The hardest case to reach from the ports is a compare value that stays equal over several prescaled cycles, or a stopped counter left sitting on it. A wrong design would repeat the action there. The bench sets a toggle action with a prescale of 3 and checks that the pin flips exactly once. It then writes the count onto the compare value while the counter is idle and checks that the pin does not move. Sweeps over prescale limits, run lengths, action codes with both initial levels, and capture edge modes on every channel compare counts and pin levels against values worked out arithmetically from the number of ticks.

// File: rtl/mc_timer_pkg.sv
package mc_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } run_state_t;

    typedef enum logic [1:0] {
        EXT_NONE   = 2'd0,
        EXT_CLEAR  = 2'd1,
        EXT_SET    = 2'd2,
        EXT_TOGGLE = 2'd3
    } ext_act_t;

    typedef enum logic [1:0] {
        SRC_CLK  = 2'd0,
        SRC_RISE = 2'd1,
        SRC_FALL = 2'd2,
        SRC_BOTH = 2'd3
    } src_mode_t;

    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_FLAG = 4'd1;
    localparam logic [3:0] A_TC   = 4'd2;
    localparam logic [3:0] A_PR   = 4'd3;
    localparam logic [3:0] A_PC   = 4'd4;
    localparam logic [3:0] A_MCFG = 4'd5;
    localparam logic [3:0] A_CCFG = 4'd6;
    localparam logic [3:0] A_EXT  = 4'd7;

endpackage

// File: rtl/mc_timer_edge.sv
module mc_timer_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] sync1, sync2, last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
            last  <= '0;
        end else begin
            sync1 <= pin;
            sync2 <= sync1;
            last  <= sync2;
        end
    end

    assign rise = sync2 & ~last;
    assign fall = ~sync2 & last;

endmodule

// File: rtl/mc_timer_count.sv
module mc_timer_count
    import mc_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_we,
    input  logic         ctrl_en,
    input  logic         ctrl_hold,
    input  logic         tc_we,
    input  logic         pc_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pr,
    input  src_mode_t    src_mode,
    input  logic         src_rise,
    input  logic         src_fall,
    input  logic         hit_rst,
    input  logic         hit_stop,
    output logic [W-1:0] tc,
    output logic [W-1:0] pc,
    output run_state_t   state,
    output logic         advance
);

    run_state_t state_nx;
    logic       src_tick;
    logic       running;

    function automatic run_state_t ctrl_target(input logic en, input logic hold);
        return hold ? ST_HOLD : (en ? ST_RUN : ST_IDLE);
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (ctrl_we) state_nx = ctrl_target(ctrl_en, ctrl_hold);
            ST_RUN: begin
                if (ctrl_we)       state_nx = ctrl_target(ctrl_en, ctrl_hold);
                else if (hit_stop) state_nx = ST_IDLE;
            end
            ST_HOLD: if (ctrl_we) state_nx = ctrl_target(ctrl_en, ctrl_hold);
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs of the machine: source tick and advance strobe
    always_comb begin
        unique case (src_mode)
            SRC_CLK:  src_tick = 1'b1;
            SRC_RISE: src_tick = src_rise;
            SRC_FALL: src_tick = src_fall;
            SRC_BOTH: src_tick = src_rise | src_fall;
            default:  src_tick = 1'b1;
        endcase
    end

    assign running = (state == ST_RUN);
    assign advance = running && src_tick && (pc == pr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc <= '0;
            pc <= '0;
        end else if (state_nx == ST_HOLD) begin
            tc <= '0;
            pc <= '0;
        end else begin
            if (running && src_tick) pc <= (pc == pr) ? '0 : pc + 1'b1;
            if (advance) begin
                if (hit_rst)       tc <= '0;
                else if (!hit_stop) tc <= tc + 1'b1;
            end
            if (pc_we) pc <= wdata;
            if (tc_we) tc <= wdata;
        end
    end

    a_r2_pc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !pc_we) |=> (pc == '0));

    a_r4_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && hit_rst && !tc_we) |=> (tc == '0));

    a_r5_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_stop && !ctrl_we) |=> (state == ST_IDLE));

    a_r6_reset_and_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_rst && hit_stop && !ctrl_we && !tc_we) |=> (tc == '0 && state == ST_IDLE));

    a_r11_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (tc == '0 && pc == '0));

endmodule

// File: rtl/mc_timer_match.sv
module mc_timer_match
    import mc_timer_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        tc,
    input  logic [N-1:0][W-1:0] mr,
    input  logic                advance,
    input  logic [N-1:0]        rst_en,
    input  logic [N-1:0]        stop_en,
    input  logic [N-1:0][1:0]   act,
    input  logic                ext_we,
    input  logic [N-1:0]        ext_wdata,
    output logic [N-1:0]        hit,
    output logic                hit_rst,
    output logic                hit_stop,
    output logic [N-1:0]        ext_out
);

    logic [N-1:0] ext_nx;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = advance && (tc == mr[g]);

        a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[g] && act[g] == 2'b11) |=> (ext_out[g] != $past(ext_out[g])));

        a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[g] && act[g] == 2'b10) |=> ext_out[g]);

        a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[g] && act[g] == 2'b01) |=> !ext_out[g]);
    end

    assign hit_rst  = |(hit & rst_en);
    assign hit_stop = |(hit & stop_en);

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ext_nx[i] = ext_we ? ext_wdata[i] : ext_out[i];
            if (hit[i]) begin
                unique case (ext_act_t'(act[i]))
                    EXT_NONE:   ext_nx[i] = ext_we ? ext_wdata[i] : ext_out[i];
                    EXT_CLEAR:  ext_nx[i] = 1'b0;
                    EXT_SET:    ext_nx[i] = 1'b1;
                    EXT_TOGGLE: ext_nx[i] = ~ext_out[i];
                    default:    ext_nx[i] = ext_out[i];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_out <= '0;
        else        ext_out <= ext_nx;
    end

endmodule

// File: rtl/mc_timer.sv
module mc_timer
    import mc_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int NCH   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic [NCH-1:0]   cap_in,
    output logic [NCH-1:0]   mat_out,
    output logic             irq
);

    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [CNT_W-1:0]            pr_q, tc, pc, rd_nx;
    logic [NCH-1:0][CNT_W-1:0]   mr_q, cr_q;
    logic [NCH-1:0]              m_irq_en, m_rst_en, m_stop_en;
    logic [NCH-1:0]              c_rise_en, c_fall_en, c_irq_en;
    logic [NCH-1:0][1:0]         ext_act;
    logic [NCH-1:0]              m_flag, c_flag, m_clr, c_clr;
    logic [NCH-1:0]              rise, fall, hit, cap_ev;
    logic [SEL_W-1:0]            src_sel;
    src_mode_t                   src_mode;
    run_state_t                  state;
    logic                        hit_rst, hit_stop, advance;
    logic we_ctrl, we_flag, we_tc, we_pr, we_pc, we_mcfg, we_ccfg, we_ext, we_mr;

    assign we_ctrl = reg_we && (reg_addr == A_CTRL);
    assign we_flag = reg_we && (reg_addr == A_FLAG);
    assign we_tc   = reg_we && (reg_addr == A_TC);
    assign we_pr   = reg_we && (reg_addr == A_PR);
    assign we_pc   = reg_we && (reg_addr == A_PC);
    assign we_mcfg = reg_we && (reg_addr == A_MCFG);
    assign we_ccfg = reg_we && (reg_addr == A_CCFG);
    assign we_ext  = reg_we && (reg_addr == A_EXT);
    assign we_mr   = reg_we && (reg_addr[3:2] == 2'b10);

    mc_timer_edge #(.N(NCH)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (cap_in),
        .rise (rise),
        .fall (fall)
    );

    mc_timer_count #(.W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (we_ctrl),
        .ctrl_en  (reg_wdata[0]),
        .ctrl_hold(reg_wdata[1]),
        .tc_we    (we_tc),
        .pc_we    (we_pc),
        .wdata    (reg_wdata),
        .pr       (pr_q),
        .src_mode (src_mode),
        .src_rise (rise[src_sel]),
        .src_fall (fall[src_sel]),
        .hit_rst  (hit_rst),
        .hit_stop (hit_stop),
        .tc       (tc),
        .pc       (pc),
        .state    (state),
        .advance  (advance)
    );

    mc_timer_match #(.N(NCH), .W(CNT_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .tc       (tc),
        .mr       (mr_q),
        .advance  (advance),
        .rst_en   (m_rst_en),
        .stop_en  (m_stop_en),
        .act      (ext_act),
        .ext_we   (we_ext),
        .ext_wdata(reg_wdata[NCH-1:0]),
        .hit      (hit),
        .hit_rst  (hit_rst),
        .hit_stop (hit_stop),
        .ext_out  (mat_out)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pr_q      <= '0;
            mr_q      <= '0;
            src_mode  <= SRC_CLK;
            src_sel   <= '0;
            m_irq_en  <= '0;
            m_rst_en  <= '0;
            m_stop_en <= '0;
            c_rise_en <= '0;
            c_fall_en <= '0;
            c_irq_en  <= '0;
            ext_act   <= '0;
        end else begin
            if (we_ctrl) begin
                src_mode <= src_mode_t'(reg_wdata[3:2]);
                src_sel  <= reg_wdata[4 +: SEL_W];
            end
            if (we_pr) pr_q <= reg_wdata;
            if (we_mr) mr_q[reg_addr[1:0]] <= reg_wdata;
            for (int i = 0; i < NCH; i++) begin
                if (we_mcfg) begin
                    m_irq_en[i]  <= reg_wdata[3*i];
                    m_rst_en[i]  <= reg_wdata[3*i+1];
                    m_stop_en[i] <= reg_wdata[3*i+2];
                end
                if (we_ccfg) begin
                    c_rise_en[i] <= reg_wdata[3*i];
                    c_fall_en[i] <= reg_wdata[3*i+1];
                    c_irq_en[i]  <= reg_wdata[3*i+2];
                end
                if (we_ext) ext_act[i] <= reg_wdata[NCH+2*i +: 2];
            end
        end
    end

    // capture channels
    for (genvar g = 0; g < NCH; g++) begin : g_cap
        assign cap_ev[g] = (c_rise_en[g] & rise[g]) | (c_fall_en[g] & fall[g]);

        a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
            cap_ev[g] |=> (cr_q[g] == $past(tc)));

        a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[g] && m_irq_en[g]) |=> m_flag[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cr_q <= '0;
        else begin
            for (int i = 0; i < NCH; i++)
                if (cap_ev[i]) cr_q[i] <= tc;
        end
    end

    // sticky flags, write one to clear, new events win
    assign m_clr = we_flag ? reg_wdata[NCH-1:0]     : '0;
    assign c_clr = we_flag ? reg_wdata[2*NCH-1:NCH] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flag <= '0;
            c_flag <= '0;
        end else begin
            m_flag <= (m_flag & ~m_clr) | (hit & m_irq_en);
            c_flag <= (c_flag & ~c_clr) | (cap_ev & c_irq_en);
        end
    end

    assign irq = |{m_flag, c_flag};

    // read path
    always_comb begin
        rd_nx = '0;
        case (reg_addr)
            A_CTRL: begin
                rd_nx[0]           = (state == ST_RUN);
                rd_nx[1]           = (state == ST_HOLD);
                rd_nx[3:2]         = src_mode;
                rd_nx[4 +: SEL_W]  = src_sel;
            end
            A_FLAG: rd_nx[2*NCH-1:0] = {c_flag, m_flag};
            A_TC:   rd_nx = tc;
            A_PR:   rd_nx = pr_q;
            A_PC:   rd_nx = pc;
            A_MCFG: for (int i = 0; i < NCH; i++)
                        rd_nx[3*i +: 3] = {m_stop_en[i], m_rst_en[i], m_irq_en[i]};
            A_CCFG: for (int i = 0; i < NCH; i++)
                        rd_nx[3*i +: 3] = {c_irq_en[i], c_fall_en[i], c_rise_en[i]};
            A_EXT: begin
                rd_nx[NCH-1:0] = mat_out;
                for (int i = 0; i < NCH; i++) rd_nx[NCH+2*i +: 2] = ext_act[i];
            end
            default: rd_nx = (reg_addr[3:2] == 2'b10) ? mr_q[reg_addr[1:0]]
                                                      : cr_q[reg_addr[1:0]];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_rdata <= '0;
        else        reg_rdata <= rd_nx;
    end

endmodule

// File: tb/mc_timer_bench.sv
module mc_timer_bench;

    localparam logic [3:0] R_CTRL = 4'd0;
    localparam logic [3:0] R_FLAG = 4'd1;
    localparam logic [3:0] R_TC   = 4'd2;
    localparam logic [3:0] R_PR   = 4'd3;
    localparam logic [3:0] R_PC   = 4'd4;
    localparam logic [3:0] R_MCFG = 4'd5;
    localparam logic [3:0] R_CCFG = 4'd6;
    localparam logic [3:0] R_EXT  = 4'd7;
    localparam logic [3:0] R_MR0  = 4'd8;
    localparam logic [3:0] R_CR0  = 4'd12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  cap_in = '0;
    logic [3:0]  mat_out;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    mc_timer u_mc_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .cap_in   (cap_in),
        .mat_out  (mat_out),
        .irq      (irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog got timeout exp completion");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp_cr [4];
        int ks [3];
        int ms [5];
        ks = '{5, 10, 17};
        ms = '{2, 3, 4, 8, 13};
        for (int i = 0; i < 4; i++) exp_cr[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(R_CTRL, d); chk("R1 ctrl", d, 32'd0);
        rd(R_TC, d);   chk("R1 count", d, 32'd0);
        rd(R_PC, d);   chk("R1 prescale counter", d, 32'd0);
        rd(R_FLAG, d); chk("R1 flags", d, 32'd0);
        chk("R1 pins", {28'd0, mat_out}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R2 prescale sweep in clock mode
        for (int p = 0; p < 4; p++) begin
            for (int j = 0; j < 3; j++) begin
                wr(R_CTRL, 32'd2);
                wr(R_MCFG, 32'd0);
                wr(R_EXT, 32'd0);
                wr(R_PR, 32'(p));
                wr(R_CTRL, 32'd1);
                repeat (ks[j]) @(negedge clk);
                wr(R_CTRL, 32'd0);
                rd(R_TC, d); chk("R2 count", d, 32'((ks[j] + 1) / (p + 1)));
                rd(R_PC, d); chk("R2 prescale", d, 32'((ks[j] + 1) % (p + 1)));
            end
        end

        // R4 periodic reset on compare 0 with interrupt (R3)
        for (int j = 0; j < 5; j++) begin
            wr(R_CTRL, 32'd2);
            wr(R_PR, 32'd0);
            wr(R_MR0, 32'd4);
            wr(R_MCFG, 32'd3);
            wr(R_FLAG, 32'hFF);
            wr(R_CTRL, 32'd1);
            repeat (ms[j]) @(negedge clk);
            wr(R_CTRL, 32'd0);
            rd(R_TC, d);   chk("R4 periodic count", d, 32'((ms[j] + 1) % 5));
            rd(R_FLAG, d); chk("R3 match flag", d, (ms[j] + 1 >= 5) ? 32'd1 : 32'd0);
            chk("R3 irq", {31'd0, irq}, (ms[j] + 1 >= 5) ? 32'd1 : 32'd0);
        end
        wr(R_FLAG, 32'd0);
        rd(R_FLAG, d); chk("R3 write zero keeps flag", d, 32'd1);
        wr(R_FLAG, 32'd1);
        rd(R_FLAG, d); chk("R3 write one clears flag", d, 32'd0);
        chk("R3 irq low", {31'd0, irq}, 32'd0);

        // R5 stop on compare 1
        wr(R_CTRL, 32'd2);
        wr(R_MCFG, 32'h20);
        wr(R_MR0 + 4'd1, 32'd6);
        wr(R_CTRL, 32'd1);
        repeat (20) @(negedge clk);
        rd(R_TC, d);   chk("R5 held at compare", d, 32'd6);
        rd(R_CTRL, d); chk("R5 stopped", d & 32'd3, 32'd0);

        // R6 reset and stop on compare 2, no interrupt
        wr(R_CTRL, 32'd2);
        wr(R_FLAG, 32'hFF);
        wr(R_MCFG, 32'h180);
        wr(R_MR0 + 4'd2, 32'd9);
        wr(R_CTRL, 32'd1);
        repeat (20) @(negedge clk);
        rd(R_TC, d);   chk("R6 count zero", d, 32'd0);
        rd(R_CTRL, d); chk("R6 stopped", d & 32'd3, 32'd0);
        rd(R_FLAG, d); chk("R3 no flag without interrupt bit", d, 32'd0);

        // R7 action codes on pin 3, both initial levels
        for (int code = 0; code < 4; code++) begin
            for (int init = 0; init < 2; init++) begin
                logic ev;
                wr(R_CTRL, 32'd2);
                wr(R_MCFG, 32'd0);
                wr(R_PR, 32'd0);
                wr(R_MR0 + 4'd3, 32'd2);
                wr(R_EXT, 32'((init << 3) | (code << 10)));
                wr(R_CTRL, 32'd1);
                repeat (10) @(negedge clk);
                wr(R_CTRL, 32'd0);
                case (code)
                    0: ev = init[0];
                    1: ev = 1'b0;
                    2: ev = 1'b1;
                    default: ev = ~init[0];
                endcase
                chk("R7 pin level", {28'd0, mat_out}, {28'd0, ev, 3'd0});
                rd(R_EXT, d);
                chk("R7 pin readback", d, 32'((code << 10)) | {28'd0, ev, 3'd0});
            end
        end

        // R10 one action per event with prescale 3
        wr(R_CTRL, 32'd2);
        wr(R_PR, 32'd3);
        wr(R_MR0 + 4'd3, 32'd1);
        wr(R_EXT, 32'(3 << 10));
        wr(R_CTRL, 32'd1);
        repeat (13) @(negedge clk);
        wr(R_CTRL, 32'd0);
        chk("R10 single toggle", {28'd0, mat_out}, 32'd8);
        rd(R_TC, d); chk("R2 prescaled count", d, 32'd3);
        wr(R_TC, 32'd1);
        repeat (8) @(negedge clk);
        chk("R10 idle on compare", {28'd0, mat_out}, 32'd8);
        rd(R_TC, d); chk("R10 idle count", d, 32'd1);
        wr(R_EXT, 32'd5);
        chk("R7 direct level write", {28'd0, mat_out}, 32'd5);
        wr(R_EXT, 32'd0);
        wr(R_PR, 32'd0);

        // R8 capture sweep: every channel, rising/falling/both
        wr(R_FLAG, 32'hFF);
        for (int ch = 0; ch < 4; ch++) begin
            for (int m = 1; m < 4; m++) begin
                logic [31:0] v1, v2;
                v1 = 32'h100 + 32'(ch * 16 + m);
                v2 = v1 + 32'h1000;
                wr(R_CCFG, 32'((m | 4) << (3 * ch)));
                wr(R_TC, v1);
                cap_in[ch] = 1'b1;
                repeat (5) @(negedge clk);
                if (m[0]) exp_cr[ch] = v1;
                rd(R_CR0 + 4'(ch), d); chk("R8 capture on rise", d, exp_cr[ch]);
                wr(R_TC, v2);
                cap_in[ch] = 1'b0;
                repeat (5) @(negedge clk);
                if (m[1]) exp_cr[ch] = v2;
                rd(R_CR0 + 4'(ch), d); chk("R8 capture on fall", d, exp_cr[ch]);
                rd(R_FLAG, d); chk("R8 capture flag", d, 32'(1 << (4 + ch)));
                wr(R_FLAG, 32'hFF);
            end
        end
        wr(R_CCFG, 32'd0);
        wr(R_TC, 32'hABC);
        cap_in[0] = 1'b1;
        repeat (5) @(negedge clk);
        cap_in[0] = 1'b0;
        repeat (5) @(negedge clk);
        rd(R_CR0, d);  chk("R8 disabled edge ignored", d, exp_cr[0]);
        rd(R_FLAG, d); chk("R8 no flag when disabled", d, 32'd0);

        // R9 pin 2 as count source
        for (int m = 1; m < 4; m++) begin
            for (int p = 0; p < 2; p++) begin
                int edges;
                wr(R_CTRL, 32'(2 | (m << 2) | (2 << 4)));
                wr(R_PR, 32'(p));
                wr(R_CTRL, 32'(1 | (m << 2) | (2 << 4)));
                for (int t = 0; t < 6; t++) begin
                    cap_in[2] = ~cap_in[2];
                    repeat (4) @(negedge clk);
                end
                wr(R_CTRL, 32'd0);
                edges = (m == 3) ? 6 : 3;
                rd(R_TC, d); chk("R9 edge count", d, 32'(edges / (p + 1)));
            end
        end

        // R11 hold
        wr(R_PR, 32'd0);
        wr(R_CTRL, 32'd1);
        repeat (5) @(negedge clk);
        wr(R_CTRL, 32'd3);
        repeat (5) @(negedge clk);
        rd(R_TC, d);   chk("R11 count zero", d, 32'd0);
        rd(R_PC, d);   chk("R11 prescale zero", d, 32'd0);
        rd(R_CTRL, d); chk("R11 hold state", d & 32'd3, 32'd2);
        wr(R_TC, 32'h55);
        rd(R_TC, d);   chk("R11 write ignored", d, 32'd0);
        wr(R_CTRL, 32'd1);
        repeat (3) @(negedge clk);
        wr(R_CTRL, 32'd0);
        rd(R_TC, d);   chk("R11 restart from zero", d, 32'd4);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule